// File: doc/BRIEF.md
# Cache-Line Coalescing Vector Gather

This block loads one vector of four 32-bit elements from a memory that is read one whole 64-byte line at a time. A request supplies a shared byte base address, one byte offset for each lane and a lane-enable mask. Lane i reads the word at base plus offset i. The unit does not read each element on its own. In each cycle it takes the lowest-numbered lane that still needs data, issues one line read for that lane's line, and marks as served every other waiting lane whose address falls in the same line. The word inside the fetched line comes from the low address bits of each lane. A gather that touches one line costs one read cycle. A gather whose lanes are spread over four lines costs four.

Requests enter and results leave through valid/ready handshakes. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the result has been handed over. The result is offered on `res_valid`, and the consumer may hold `res_ready` low for as long as it needs. The line-read port has no handshake. The memory must return the addressed line on `rd_data` in the cycle after `rd_en`.

Top module: `vec_line_gather`

## Requirements
- R1: After reset `req_ready` is 1, and `res_valid` and `rd_en` are 0.
- R2: The effective address of lane i is `req_base + req_offs[32i+31:32i]`, taken modulo 2^32 and treated as 4-byte aligned. Its bits [31:6] are the line index and bits [5:2] select the word within the line.
- R3: Each read cycle drives `rd_line_addr` with the line index of the lowest-numbered enabled lane not yet served.
- R4: All waiting lanes that share the line being read are served by that one read. The number of cycles with `rd_en` high per gather equals the number of distinct lines among the enabled lanes (1 to 4), and those cycles follow the accepting edge back to back.
- R5: In the result, lane i's element sits at `res_data[32i+31:32i]`. It equals word w of its line, and the memory presents word w on `rd_data[32w+31:32w]`.
- R6: A lane with a 0 in `req_mask` returns zero and causes no read. With an all-zero mask there is no read, and `res_valid` is high right after the accepting edge.
- R7: For a gather that touches n ≥ 1 lines, `res_valid` first becomes high after the (n+1)-th clock edge that follows the accepting edge.
- R8: `req_ready` is low from the accepting edge until the edge where the result is taken, and it is high again right after that edge.
- R9: While `res_valid` is high and `res_ready` is low, `res_valid` stays high and `res_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_base | input | 32 | Common byte base address |
| req_offs | input | 128 | Four byte offsets, lane i at bits [32i+31:32i] |
| req_mask | input | 4 | Lane enables, bit i for lane i |
| rd_en | output | 1 | Line read strobe |
| rd_line_addr | output | 26 | Index of the line to read |
| rd_data | input | 512 | Line returned one cycle after `rd_en`, word w at [32w+31:32w] |
| res_valid | output | 1 | Gathered vector available |
| res_ready | input | 1 | Consumer takes the vector |
| res_data | output | 128 | Gathered vector, lane i at [32i+31:32i] |

## Verification
The assertions assume that the memory answers every `rd_en` with the matching line in the next cycle. They also assume that offsets give word-aligned effective addresses, since the two lowest address bits are dropped instead of being checked. The bench's line memory is a registered lookup computed from the line index, so the one-cycle latency always holds. Every offset it sends is a multiple of four, including the cases that cross a line boundary and the case where the address wraps past 2^32. The consumer holds `res_ready` low for varying stretches, and the producer offers requests only while `req_ready` is high.

// File: rtl/lg_pkg.sv
package lg_pkg;

  // Control sequence of one gather
  typedef enum logic [1:0] {
    GS_IDLE = 2'd0,   // waiting for a request
    GS_RUN  = 2'd1,   // one line read per cycle
    GS_FILL = 2'd2,   // last line arriving
    GS_DONE = 2'd3    // result offered
  } gstate_e;

endpackage

// File: rtl/lg_addr_gen.sv
module lg_addr_gen #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 2,
  parameter int WSEL_W = 4,
  parameter int TAG_W  = 26
) (
  input  logic [ADDR_W-1:0]             base,
  input  logic [LANES*ADDR_W-1:0]       offs,
  output logic [LANES-1:0][TAG_W-1:0]   tags,
  output logic [LANES-1:0][WSEL_W-1:0]  wsels
);

  logic [LANES-1:0][ADDR_W-1:0] eff;
  logic [LANES-1:0]             unused_low;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign eff[l]        = base + offs[l*ADDR_W +: ADDR_W];
    assign tags[l]       = eff[l][ADDR_W-1 -: TAG_W];
    assign wsels[l]      = eff[l][BYTE_W +: WSEL_W];
    assign unused_low[l] = ^eff[l][BYTE_W-1:0];
  end

endmodule

// File: rtl/lg_lane_pick.sv
module lg_lane_pick #(
  parameter int LANES = 4,
  parameter int TAG_W = 26
) (
  input  logic [LANES-1:0]            pending,
  input  logic [LANES-1:0][TAG_W-1:0] tags,
  output logic [TAG_W-1:0]            sel_tag,
  output logic [LANES-1:0]            hit_mask,
  output logic                        any
);

  // Lowest-numbered waiting lane decides the line
  always_comb begin
    sel_tag = '0;
    any     = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (pending[l] && !any) begin
        any     = 1'b1;
        sel_tag = tags[l];
      end
    end
  end

  // Upper-bit compare against the chosen line
  for (genvar l = 0; l < LANES; l++) begin : g_cmp
    assign hit_mask[l] = pending[l] && (tags[l] == sel_tag);
  end

endmodule

// File: rtl/lg_word_sel.sv
module lg_word_sel #(
  parameter int LANES      = 4,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 16,
  parameter int WSEL_W     = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 clear,
  input  logic [LANES-1:0]                     cap_mask,
  input  logic [LANES-1:0][WSEL_W-1:0]         wsels,
  input  logic [LINE_WORDS*WORD_W-1:0]         line_data,
  output logic [LANES*WORD_W-1:0]              result
);

  logic [LINE_WORDS-1:0][WORD_W-1:0] line_words;
  logic [LANES-1:0][WORD_W-1:0]      res_q;

  assign line_words = line_data;
  assign result     = res_q;

  for (genvar l = 0; l < LANES; l++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q[l] <= '0;
      end else if (clear) begin
        res_q[l] <= '0;
      end else if (cap_mask[l]) begin
        res_q[l] <= line_words[wsels[l]];
      end
    end
  end

endmodule

// File: rtl/vec_line_gather.sv
module vec_line_gather #(
  parameter int LANES      = 4,
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   req_valid,
  output logic                                   req_ready,
  input  logic [ADDR_W-1:0]                      req_base,
  input  logic [LANES*ADDR_W-1:0]                req_offs,
  input  logic [LANES-1:0]                       req_mask,
  output logic                                   rd_en,
  output logic [ADDR_W-$clog2(WORD_W/8)-$clog2(LINE_WORDS)-1:0] rd_line_addr,
  input  logic [LINE_WORDS*WORD_W-1:0]           rd_data,
  output logic                                   res_valid,
  input  logic                                   res_ready,
  output logic [LANES*WORD_W-1:0]                res_data
);
  import lg_pkg::*;

  localparam int BYTE_W = $clog2(WORD_W/8);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int TAG_W  = ADDR_W - BYTE_W - WSEL_W;

  gstate_e                       state_q;
  logic [LANES-1:0]              pending_q;
  logic [LANES-1:0]              cap_q;
  logic [LANES-1:0][TAG_W-1:0]   tag_q;
  logic [LANES-1:0][WSEL_W-1:0]  wsel_q;

  logic [LANES-1:0][TAG_W-1:0]   tag_d;
  logic [LANES-1:0][WSEL_W-1:0]  wsel_d;
  logic [TAG_W-1:0]              sel_tag;
  logic [LANES-1:0]              hit_mask;
  logic                          any_pend;
  logic [LANES-1:0]              left_after;
  logic                          accept;

  lg_addr_gen #(
    .LANES (LANES), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W),
    .WSEL_W(WSEL_W), .TAG_W (TAG_W)
  ) u_addr (
    .base (req_base),
    .offs (req_offs),
    .tags (tag_d),
    .wsels(wsel_d)
  );

  lg_lane_pick #(.LANES(LANES), .TAG_W(TAG_W)) u_pick (
    .pending (pending_q),
    .tags    (tag_q),
    .sel_tag (sel_tag),
    .hit_mask(hit_mask),
    .any     (any_pend)
  );

  lg_word_sel #(
    .LANES(LANES), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .WSEL_W(WSEL_W)
  ) u_words (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .cap_mask (cap_q),
    .wsels    (wsel_q),
    .line_data(rd_data),
    .result   (res_data)
  );

  assign req_ready    = (state_q == GS_IDLE);
  assign accept       = req_valid && req_ready;
  assign rd_en        = (state_q == GS_RUN) && any_pend;
  assign rd_line_addr = rd_en ? sel_tag : '0;
  assign res_valid    = (state_q == GS_DONE);
  assign left_after   = pending_q & ~hit_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= GS_IDLE;
      pending_q <= '0;
      cap_q     <= '0;
      tag_q     <= '0;
      wsel_q    <= '0;
    end else begin
      unique case (state_q)
        GS_IDLE: begin
          cap_q <= '0;
          if (accept) begin
            tag_q     <= tag_d;
            wsel_q    <= wsel_d;
            pending_q <= req_mask;
            state_q   <= (req_mask == '0) ? GS_DONE : GS_RUN;
          end
        end
        GS_RUN: begin
          pending_q <= left_after;
          cap_q     <= hit_mask;
          if (left_after == '0) state_q <= GS_FILL;
        end
        GS_FILL: begin
          cap_q   <= '0;
          state_q <= GS_DONE;
        end
        GS_DONE: begin
          cap_q <= '0;
          if (res_ready) state_q <= GS_IDLE;
        end
        default: state_q <= GS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lg_gather_chk.sv
module lg_gather_chk #(
  parameter int LANES      = 4,
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic                      rd_en,
  input logic [ADDR_W-$clog2(WORD_W/8)-$clog2(LINE_WORDS)-1:0] rd_line_addr,
  input logic                      res_valid,
  input logic                      res_ready,
  input logic [LANES*WORD_W-1:0]   res_data
);

  localparam int CNT_W = $clog2(LANES + 1) + 1;

  logic [CNT_W-1:0] rd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     rd_cnt <= '0;
    else if (req_valid && req_ready) rd_cnt <= '0;
    else if (rd_en)                  rd_cnt <= rd_cnt + 1'b1;
  end

  // R8
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R8
  read_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !req_ready);

  // R4
  read_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_cnt < CNT_W'(LANES)));

  // R4
  distinct_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (rd_line_addr != $past(rd_line_addr)));

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  // R7
  no_read_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !rd_en);

endmodule

bind vec_line_gather lg_gather_chk #(
  .LANES(LANES), .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)
) u_gather_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rd_en       (rd_en),
  .rd_line_addr(rd_line_addr),
  .res_valid   (res_valid),
  .res_ready   (res_ready),
  .res_data    (res_data)
);

// File: tb/test_vec_line_gather.sv
`timescale 1ns/1ps
module test_vec_line_gather;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [31:0]  req_base = '0;
  logic [127:0] req_offs = '0;
  logic [3:0]   req_mask = '0;
  logic         rd_en;
  logic [25:0]  rd_line_addr;
  logic [511:0] rd_data = '0;
  logic         res_valid;
  logic         res_ready = 1'b0;
  logic [127:0] res_data;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  vec_line_gather i_vec_line_gather (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_base(req_base), .req_offs(req_offs), .req_mask(req_mask),
    .rd_en(rd_en), .rd_line_addr(rd_line_addr), .rd_data(rd_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  function automatic logic [31:0] mem_word(input logic [25:0] line, input int w);
    logic [31:0] x;
    x = {6'd0, line} * 32'h9E3779B1;
    x = x ^ (w * 32'h01000193) ^ 32'h5A5A0F0F;
    return x;
  endfunction

  // Line memory: registered, one cycle after the read strobe
  always @(posedge clk) begin
    if (rd_en) begin
      for (int w = 0; w < 16; w++) rd_data[32*w +: 32] <= mem_word(rd_line_addr, w);
    end
  end

  task automatic chk(input bit ok, input string req,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic run_gather(input logic [31:0] base, input logic [127:0] offs,
                            input logic [3:0] mask, input int hold, input string tag);
    logic [25:0]  lines[$];
    logic [127:0] exp_res;
    logic [127:0] held;
    logic [3:0]   pend;
    logic [31:0]  ea;
    int           n;
    int           reads;
    bit           zero;
    bit           got;
    exp_res = '0;
    for (int l = 0; l < 4; l++) begin
      ea = base + offs[32*l +: 32];
      if (mask[l]) exp_res[32*l +: 32] = mem_word(ea[31:6], int'(ea[5:2]));
    end
    pend = mask;
    while (pend != 0) begin
      logic [25:0] t;
      int first;
      first = -1;
      for (int l = 3; l >= 0; l--) if (pend[l]) first = l;
      ea = base + offs[32*first +: 32];
      t  = ea[31:6];
      lines.push_back(t);
      for (int l = 0; l < 4; l++) begin
        ea = base + offs[32*l +: 32];
        if (pend[l] && ea[31:6] == t) pend[l] = 1'b0;
      end
    end
    n = lines.size();
    zero = (mask == 0);
    reads = 0;
    got = 1'b0;

    @(negedge clk);
    chk(req_ready == 1'b1, {"R8 ready before ", tag}, {127'd0, req_ready}, 128'd1);
    req_valid = 1'b1; req_base = base; req_offs = offs; req_mask = mask;
    for (int k = 1; k <= 14 && !got; k++) begin
      bit exp_rd;
      bit exp_rv;
      @(negedge clk);
      req_valid = 1'b0;
      exp_rd = !zero && (k <= n);
      exp_rv = zero ? 1'b1 : (k >= n + 2);
      if (rd_en) reads++;
      chk(rd_en == exp_rd, {"R4 read strobe ", tag}, {127'd0, rd_en}, {127'd0, exp_rd});
      if (exp_rd && rd_en)
        chk(rd_line_addr == lines[k-1], {"R3 line order ", tag},
            {102'd0, rd_line_addr}, {102'd0, lines[k-1]});
      chk(res_valid == exp_rv, zero ? {"R6 zero-mask timing ", tag} : {"R7 result timing ", tag},
          {127'd0, res_valid}, {127'd0, exp_rv});
      if (res_valid) got = 1'b1;
      else chk(req_ready == 1'b0, {"R8 busy ", tag}, {127'd0, req_ready}, 128'd0);
    end
    if (!got) begin
      chk(1'b0, {"R7 result never arrived ", tag}, 128'd0, 128'd1);
      return;
    end
    chk(reads == n, {"R4 read count ", tag}, 128'(reads), 128'(n));
    chk(res_data == exp_res, {"R2/R5 data ", tag}, res_data, exp_res);
    held = res_data;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(res_valid && res_data == held, {"R9 hold ", tag}, res_data, held);
      chk(req_ready == 1'b0, {"R8 busy while held ", tag}, {127'd0, req_ready}, 128'd0);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(!res_valid && req_ready, {"R8 released ", tag},
        {126'd0, res_valid, req_ready}, 128'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 128'd0, 128'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(req_ready && !res_valid && !rd_en, "R1 reset state",
        {125'd0, req_ready, res_valid, rd_en}, 128'h4);

    run_gather(32'h0000_1000, {32'd60, 32'd8, 32'd4, 32'd0}, 4'hF, 0, "one line");
    run_gather(32'h0000_2000, {32'd192, 32'd128, 32'd64, 32'd0}, 4'hF, 2, "four lines");
    run_gather(32'h0000_3000, {32'd68, 32'd12, 32'd64, 32'd0}, 4'hF, 0, "two lines interleaved");
    run_gather(32'h0000_4000, {32'd0, 32'd64, 32'd128, 32'd192}, 4'h0, 1, "zero mask");
    run_gather(32'h0000_5000, {32'd256, 32'd20, 32'd512, 32'd4}, 4'b0101, 0, "masked lanes");
    run_gather(32'h0000_603C, {32'd8, 32'd4, 32'd0, 32'd4}, 4'hF, 0, "line crossing");
    run_gather(32'h0000_7000, {32'd4, 32'd8, 32'd0, 32'd128}, 4'hF, 3, "high lane first");
    run_gather(32'hFFFF_FFC0, {32'd40, 32'd64, 32'd0, 32'd68}, 4'hF, 0, "address wrap");
    run_gather(32'h0001_0000, {32'd256, 32'd128, 32'd64, 32'd0}, 4'b1000, 4, "single lane");
    finish_run();
  end

endmodule